// File: doc/BRIEF.md
# Oversampling Asynchronous Frame Receiver

This block recovers characters from an asynchronous serial line. A one-cycle enable pulse at sixteen times the bit rate paces the block. The line input first passes through a short chain of synchronising flops. A falling edge is then taken as a possible start bit, and the block confirms it half a bit later. After that it samples every data bit, the optional parity bit and one stop bit at the centre of the bit. The finished character goes into a receive buffer, and four sticky status bits tell the host what happened.

The character format comes from the same line-control fields the transmitter uses: word length, parity enable, even-parity select and stick parity. The host acts through two one-cycle read strobes. One consumes the buffer. The other consumes the error bits. Routing the transmitter's output back to this input for self-test is the parent's job.

Top module: `uart_oversample_rx`

## Requirements
- R1: After reset, `line_stat` is 4'b0000 and `rx_buf` is 8'h00.
- R2: `word_len` selects 5, 6, 7 or 8 data bits for 2'b00, 2'b01, 2'b10 and 2'b11. Data arrives least significant bit first, and buffer bits above the programmed length read 0.
- R3: A start bit is detected on a tick that sees the synchronised line low. It is accepted only if the line is still low at the 8th tick after that detection tick. Otherwise the block returns to idle and the buffer and status do not change.
- R4: Each later bit is sampled 16 ticks after the one before it. On the clock edge of the stop-bit sample, `rx_buf` loads the character and `line_stat[0]` (data ready) is set.
- R5: With `par_en` high and `par_stick` low, the ones in the data plus the parity bit must be even when `par_even` is 1 and odd when it is 0. A mismatch sets `line_stat[2]`.
- R6: With `par_en` and `par_stick` high, the parity bit must be 1 when `par_even` is 0 and 0 when `par_even` is 1. A mismatch sets `line_stat[2]`.
- R7: A stop bit sampled as 0 sets `line_stat[3]`. The character is still loaded and data ready is still set.
- R8: A character that completes while data ready is set, with no buffer read in the same cycle, sets `line_stat[1]`. The buffer then holds the newer character.
- R9: A `buf_rd` pulse clears data ready, unless a character completes in the same cycle.
- R10: A `stat_rd` pulse clears `line_stat[3:1]`. An error flagged in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| ser_in | input | 1 | Serial line, idle high |
| word_len | input | 2 | Data-bit count code (5 to 8) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select; in stick mode, the inverse of the expected bit |
| par_stick | input | 1 | Parity bit checked against a fixed level |
| buf_rd | input | 1 | Buffer read strobe |
| stat_rd | input | 1 | Status read strobe |
| rx_buf | output | 8 | Received character, zero-extended |
| line_stat | output | 4 | {framing, parity, overrun, data ready} |

## Verification
The properties assume three things about the inputs. `baud_tick` is a single-cycle pulse. The format fields do not change while a frame is in flight. The read strobes are one cycle wide. The stimulus produces ticks from a fixed divider and changes the format only during idle gaps of two bit times. It drives every line bit for exactly sixteen tick periods, and it drives all inputs on the falling clock edge, so no sample lands on a transition.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  localparam int CHAR_W = 8;

  // index of the last data bit for a word-length code
  function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  localparam int CW = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              perr,
  output logic              ferr
);

  localparam logic [CW-1:0] HALF_LAST = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);

  rx_state_t         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [2:0]        nb_q, nb_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              pb_q, pb_d;
  logic              adv;
  logic              par_x;

  assign adv = tick && (st_q != RX_IDLE) && (st_q != RX_START) ? (cnt_q == FULL_LAST) : 1'b0;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    nb_d  = nb_q;
    sh_d  = sh_q;
    pb_d  = pb_q;
    done  = 1'b0;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (cnt_q == HALF_LAST) begin
            cnt_d = '0;
            nb_d  = '0;
            st_d  = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (adv) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[CHAR_W-1:1]};
            if (nb_q == last_bit_idx(word_len)) st_d = par_en ? RX_PAR : RX_STOP;
            else                                nb_d = nb_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (adv) begin
            cnt_d = '0;
            pb_d  = line;
            st_d  = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (adv) begin
            cnt_d = '0;
            done  = 1'b1;
            st_d  = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      nb_q  <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
    end else if (tick) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      nb_q  <= nb_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
    end
  end

  // right-justify the shifted character and zero the unused top bits
  always_comb begin
    unique case (word_len)
      2'b00:   data = {3'b000, sh_q[7:3]};
      2'b01:   data = {2'b00,  sh_q[7:2]};
      2'b10:   data = {1'b0,   sh_q[7:1]};
      default: data = sh_q;
    endcase
  end

  assign par_x = ^data;
  assign perr  = done && par_en &&
                 (par_stick ? (pb_q == par_even) : ((par_x ^ pb_q) == par_even));
  assign ferr  = done && !line;

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] ld_data,
  input  logic              ld_perr,
  input  logic              ld_ferr,
  input  logic              buf_rd,
  input  logic              stat_rd,
  output logic [CHAR_W-1:0] rx_buf,
  output logic [3:0]        line_stat
);

  logic [CHAR_W-1:0] buf_q, buf_d;
  logic dr_q, dr_d, oe_q, oe_d, pe_q, pe_d, fe_q, fe_d;
  logic upd;

  assign upd = load | buf_rd | stat_rd;

  always_comb begin
    buf_d = buf_q;
    dr_d  = dr_q;
    oe_d  = oe_q;
    pe_d  = pe_q;
    fe_d  = fe_q;
    if (stat_rd) begin
      oe_d = 1'b0;
      pe_d = 1'b0;
      fe_d = 1'b0;
    end
    if (buf_rd) dr_d = 1'b0;
    if (load) begin
      buf_d = ld_data;
      dr_d  = 1'b1;
      if (dr_q && !buf_rd) oe_d = 1'b1;
      if (ld_perr)         pe_d = 1'b1;
      if (ld_ferr)         fe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      dr_q  <= 1'b0;
      oe_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
    end else if (upd) begin
      buf_q <= buf_d;
      dr_q  <= dr_d;
      oe_q  <= oe_d;
      pe_q  <= pe_d;
      fe_q  <= fe_d;
    end
  end

  assign rx_buf    = buf_q;
  assign line_stat = {fe_q, pe_q, oe_q, dr_q};

endmodule

// File: rtl/uart_oversample_rx.sv
module uart_oversample_rx #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       ser_in,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       buf_rd,
  input  logic       stat_rd,
  output logic [7:0] rx_buf,
  output logic [3:0] line_stat
);

  logic       line_s;
  logic       frm_done;
  logic [7:0] frm_data;
  logic       frm_perr;
  logic       frm_ferr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (ser_in),
    .q_out (line_s)
  );

  uart_rx_frame #(.OVS(OVS)) i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .line      (line_s),
    .word_len  (word_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .done      (frm_done),
    .data      (frm_data),
    .perr      (frm_perr),
    .ferr      (frm_ferr)
  );

  uart_rx_status i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frm_done),
    .ld_data   (frm_data),
    .ld_perr   (frm_perr),
    .ld_ferr   (frm_ferr),
    .buf_rd    (buf_rd),
    .stat_rd   (stat_rd),
    .rx_buf    (rx_buf),
    .line_stat (line_stat)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic [1:0] word_len,
  input logic       buf_rd,
  input logic       stat_rd,
  input logic       load,
  input logic [7:0] rx_buf,
  input logic [3:0] line_stat
);

  a_r4_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> line_stat[0]);

  a_r9_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !load) |=> !line_stat[0]);

  a_r10_stat_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !load) |=> (line_stat[3:1] == 3'b000));

  a_r8_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_stat[1]) |-> ($past(line_stat[0]) && $past(load)));

  a_r5_parity_flag_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_stat[2]) |-> $past(load));

  a_r2_short_word_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word_len != 2'b11) |=> (rx_buf[7] == 1'b0));

  a_r3_load_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> baud_tick);

endmodule

bind uart_oversample_rx uart_rx_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .baud_tick (baud_tick),
  .word_len  (word_len),
  .buf_rd    (buf_rd),
  .stat_rd   (stat_rd),
  .load      (frm_done),
  .rx_buf    (rx_buf),
  .line_stat (line_stat)
);

// File: tb/test_uart_oversample_rx.sv
module test_uart_oversample_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int OVS        = 16;
  localparam int SYNC       = 2;
  localparam int BITLEN     = OVS * DIV;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       ser_in = 1'b1;
  logic [1:0] word_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       par_stick = 1'b0;
  logic       buf_rd = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] rx_buf;
  logic [3:0] line_stat;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  uart_oversample_rx #(.OVS(OVS), .SYNC_STAGES(SYNC)) i_uart_oversample_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .ser_in    (ser_in),
    .word_len  (word_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .buf_rd    (buf_rd),
    .stat_rd   (stat_rd),
    .rx_buf    (rx_buf),
    .line_stat (line_stat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick generator, driven on the falling edge
  int tdiv = 0;
  always @(negedge clk) begin
    if (tdiv == DIV-1) begin
      tdiv = 0;
      baud_tick = 1'b1;
    end else begin
      tdiv = tdiv + 1;
      baud_tick = 1'b0;
    end
  end

  // behavioural reference model
  int sy [SYNC];
  int ph, cnt, nb, acc, pbit;
  bit m_dr, m_oe, m_pe, m_fe;
  int m_buf;

  always @(posedge clk) begin
    int  line;
    bit  fin, perr, ferr, old_dr;
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) sy[k] = 1;
      ph = 0; cnt = 0; nb = 0; acc = 0; pbit = 0;
      m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_buf = 0;
    end else begin
      line = sy[SYNC-1];
      for (int k = SYNC-1; k > 0; k--) sy[k] = sy[k-1];
      sy[0] = ser_in;
      fin = 0; perr = 0; ferr = 0;
      if (baud_tick) begin
        case (ph)
          0: if (line == 0) begin ph = 1; cnt = 0; end
          1: if (cnt == OVS/2-1) begin
               cnt = 0;
               if (line == 0) begin ph = 2; nb = 0; acc = 0; end
               else ph = 0;
             end else cnt++;
          2: if (cnt == OVS-1) begin
               cnt = 0;
               acc = acc | (line << nb);
               nb++;
               if (nb == int'(word_len) + 5) ph = par_en ? 3 : 4;
             end else cnt++;
          3: if (cnt == OVS-1) begin cnt = 0; pbit = line; ph = 4; end
             else cnt++;
          default: if (cnt == OVS-1) begin
               cnt = 0; ph = 0; fin = 1;
               ferr = (line == 0);
               if (par_en) begin
                 if (par_stick) perr = (pbit != int'(!par_even));
                 else perr = ((($countones(acc) + pbit) % 2) != int'(!par_even));
               end
             end else cnt++;
        endcase
      end
      old_dr = m_dr;
      if (stat_rd) begin m_oe = 0; m_pe = 0; m_fe = 0; end
      if (buf_rd) m_dr = 0;
      if (fin) begin
        m_buf = acc;
        m_dr  = 1;
        if (old_dr && !buf_rd) m_oe = 1;
        if (perr) m_pe = 1;
        if (ferr) m_fe = 1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (rx_buf !== m_buf[7:0]) begin
        fails++; $display("FAIL R2 rx_buf actual %h expected %h", rx_buf, m_buf[7:0]);
      end
      if (line_stat[0] !== m_dr) begin
        fails++; $display("FAIL R4 ready actual %b expected %b", line_stat[0], m_dr);
      end
      if (line_stat[1] !== m_oe) begin
        fails++; $display("FAIL R8 overrun actual %b expected %b", line_stat[1], m_oe);
      end
      if (line_stat[2] !== m_pe) begin
        fails++; $display("FAIL R5 parity actual %b expected %b", line_stat[2], m_pe);
      end
      if (line_stat[3] !== m_fe) begin
        fails++; $display("FAIL R7 framing actual %b expected %b", line_stat[3], m_fe);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit stop_v);
    int  n;
    bit  pb;
    bit  bits[$];
    n = int'(word_len) + 5;
    bits.push_back(1'b0);
    for (int i = 0; i < n; i++) bits.push_back(d[i]);
    if (par_en) begin
      if (par_stick) pb = !par_even;
      else begin
        pb = !par_even;
        for (int i = 0; i < n; i++) pb = pb ^ d[i];
      end
      bits.push_back(pb ^ flip_par);
    end
    bits.push_back(stop_v);
    foreach (bits[i]) begin
      ser_in = bits[i];
      idle(BITLEN);
    end
    ser_in = 1'b1;
    idle(2*BITLEN);
  endtask

  task automatic pulse_buf_rd();
    buf_rd = 1'b1; idle(1); buf_rd = 1'b0; idle(2);
  endtask

  task automatic pulse_stat_rd();
    stat_rd = 1'b1; idle(1); stat_rd = 1'b0; idle(2);
  endtask

  task automatic set_fmt(input logic [1:0] wl, input bit pe, input bit ev, input bit st);
    word_len = wl; par_en = pe; par_even = ev; par_stick = st;
    idle(BITLEN);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      fails++;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check(line_stat == 4'b0000, "R1 status", line_stat, 0);
    check(rx_buf == 8'h00, "R1 buffer", rx_buf, 0);

    // R4 eight bits, no parity
    set_fmt(2'b11, 0, 0, 0);
    send_frame(8'hA5, 0, 1);
    check(rx_buf == 8'hA5, "R4 buffer", rx_buf, 8'hA5);
    check(line_stat == 4'b0001, "R4 status", line_stat, 1);
    pulse_buf_rd();
    check(line_stat[0] == 1'b0, "R9 ready cleared", line_stat, 0);

    // R2 five bits, odd parity, upper bits zero
    set_fmt(2'b00, 1, 0, 0);
    send_frame(8'hFF, 0, 1);
    check(rx_buf == 8'h1F, "R2 five-bit", rx_buf, 8'h1F);
    check(line_stat == 4'b0001, "R5 odd ok", line_stat, 1);
    pulse_buf_rd();

    // R5 six bits, even parity, corrupted
    set_fmt(2'b01, 1, 1, 0);
    send_frame(8'hEA, 1, 1);
    check(rx_buf == 8'h2A, "R2 six-bit", rx_buf, 8'h2A);
    check(line_stat == 4'b0101, "R5 even error", line_stat, 5);
    pulse_stat_rd();
    check(line_stat == 4'b0001, "R10 errors cleared", line_stat, 1);
    pulse_buf_rd();

    // R6 stick parity, both levels
    set_fmt(2'b10, 1, 0, 1);
    send_frame(8'h55, 0, 1);
    check(line_stat == 4'b0001, "R6 stick one ok", line_stat, 1);
    check(rx_buf == 8'h55, "R2 seven-bit", rx_buf, 8'h55);
    pulse_buf_rd();
    set_fmt(2'b10, 1, 1, 1);
    send_frame(8'h0F, 1, 1);
    check(line_stat == 4'b0101, "R6 stick zero error", line_stat, 5);
    pulse_stat_rd();
    pulse_buf_rd();

    // R7 framing error
    set_fmt(2'b11, 0, 0, 0);
    send_frame(8'h3C, 0, 0);
    check(line_stat == 4'b1001, "R7 framing", line_stat, 9);
    check(rx_buf == 8'h3C, "R7 buffer", rx_buf, 8'h3C);
    pulse_stat_rd();
    pulse_buf_rd();

    // R8 overrun
    send_frame(8'h11, 0, 1);
    send_frame(8'h22, 0, 1);
    check(line_stat == 4'b0011, "R8 overrun", line_stat, 3);
    check(rx_buf == 8'h22, "R8 newer kept", rx_buf, 8'h22);
    pulse_stat_rd();
    pulse_buf_rd();

    // R3 short low pulse is rejected
    ser_in = 1'b0;
    idle(3*DIV);
    ser_in = 1'b1;
    idle(3*BITLEN);
    check(line_stat == 4'b0000, "R3 glitch status", line_stat, 0);
    check(rx_buf == 8'h22, "R3 glitch buffer", rx_buf, 8'h22);

    // receiver still works afterwards
    send_frame(8'h81, 0, 1);
    check(rx_buf == 8'h81, "R4 after glitch", rx_buf, 8'h81);

    idle(4);
    finish_run();
  end

endmodule